// File: doc/BRIEF.md
# SPI EEPROM Page Write Controller

This block stores a run of 16-bit words into a serial EEPROM that is reached over a bit-banged four-wire SPI link. A requester pulses `start` with a starting word index and a word count. The block checks those values against the device size. It then walks the run in bursts and fetches each data word through a combinational lookup port (`word_idx` out, `word_data` in).

Every burst follows the same steps. The block gains access to the link through a request/grant handshake. It polls the device status until the device is idle, then sends a write-enable command. Next it sends the write command with the byte address and streams words until the run ends or the next byte address lands on a page boundary. Before it releases the link, it waits out the device's internal programming time. `busy` covers the whole operation. A one-cycle `done` or `err` pulse reports how it ended.

Top module: `spi_page_writer`

## Requirements
- R1: A start whose offset is at or above the device word count, whose count is zero, or whose count is larger than the words left after the offset gets a one-cycle `err` pulse. `busy` stays low and `acc_req` never rises. The largest legal run, which ends on the last device word, is accepted.
- R2: Before each burst `acc_req` is raised. If `acc_gnt` is not seen within GRANT_POLLS cycles, `acc_req` drops and `err` pulses. Chip select stays deasserted (high) whenever `acc_req` is low.
- R3: The ready check drives chip select low and then sends status opcode 0x05 (OPC_W bits) followed by 8 input bits. Bit 0 of the status byte set to 1 means busy; in that case chip select is pulsed high then low and the poll repeats. After READY_TRIES busy replies, the link is released and `err` pulses.
- R4: Each burst sends write-enable opcode 0x06 as a frame of its own, with chip select pulsed high then low before and after it.
- R5: The write opcode is 0x02. When ADDR_W is 8 and the burst's first word index is 128 or more, bit 3 is also set, giving 0x0A.
- R6: The address that follows the write opcode is twice the burst's first word index, cut to ADDR_W bits and sent MSB first.
- R7: Each data word is sent as 16 bits, low byte first and each byte MSB first. The device therefore holds the low byte at byte address 2i and the high byte at 2i+1.
- R8: A burst ends with a chip-select pulse when the next word starts a new page (byte address a multiple of PAGE_BYTES) and words remain. If the run ends at the same point, it ends without that pulse.
- R9: After the last data bit of a burst, the block waits at least PROG_CYCLES cycles. It then releases the link by raising chip select and lowering `acc_req`.
- R10: A data bit is set on `spi_mosi` before `spi_sck` rises and is held while it is high. `spi_sck` falls after every bit, and `spi_mosi` is 0 once a shift completes. `spi_sck` is low while chip select is high.
- R11: `busy` rises on the clock edge that accepts a legal start and falls on the edge that raises `done` or `err`. The two pulses never coincide.
- R12: After reset, chip select is high, `spi_sck`, `spi_mosi`, `acc_req`, `busy`, `done` and `err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, accepted only while idle |
| start_offset | input | IDX_W | First word index of the run |
| start_count | input | IDX_W | Number of words in the run |
| word_idx | output | IDX_W | Index of the word currently being fetched |
| word_data | input | 16 | Data word at `word_idx` |
| acc_req | output | 1 | Link access request |
| acc_gnt | input | 1 | Link access grant |
| spi_cs | output | 1 | Chip select, active low |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the device |
| spi_miso | input | 1 | Serial data from the device |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse on successful completion |
| err | output | 1 | One-cycle pulse on rejection or failure |

## Verification
Two decisions can fall on the same word: the run running out, and the next byte address crossing a page boundary. The bench provokes this with a run that ends exactly at the end of a page. It judges the result by counting chip-select falls on a behavioural device model and finds no extra pulse. A run that crosses a boundary mid-stream must instead show a second write frame. A cycle-level model of `busy` built from accepted starts and completion pulses is compared on every clock. The device model rebuilds the written memory from the bus alone, so byte order, address folding and opcode choice are all judged from the wire.

// File: rtl/spi_pw_pkg.sv
package spi_pw_pkg;

   typedef enum logic [3:0] {
      S_IDLE, S_ACQ, S_SEL, S_RDSR, S_STAT, S_PHI, S_PLO,
      S_WREN, S_WROP, S_ADDR, S_DATA, S_NEXT, S_PROG
   } pw_state_e;

   typedef enum logic [1:0] {
      PH_SETUP, PH_HIGH, PH_LOW
   } sh_phase_e;

   localparam logic [7:0] OP_STATUS = 8'h05;
   localparam logic [7:0] OP_WREN   = 8'h06;
   localparam logic [7:0] OP_WRITE  = 8'h02;
   localparam logic [7:0] OP_HIADDR = 8'h08;

endpackage

// File: rtl/spi_pw_bounds.sv
module spi_pw_bounds #(
   parameter int DEV_WORDS = 256,
   parameter int IDX_W     = 16
) (
   input  logic [IDX_W-1:0] offset,
   input  logic [IDX_W-1:0] count,
   output logic             bad
);
   localparam logic [IDX_W:0] LIM = (IDX_W+1)'(DEV_WORDS);

   logic [IDX_W:0] off_w, cnt_w;

   always_comb begin
      off_w = {1'b0, offset};
      cnt_w = {1'b0, count};
      bad   = (off_w >= LIM) || (cnt_w == '0) || (cnt_w > (LIM - off_w));
   end
endmodule

// File: rtl/spi_pw_shifter.sv
module spi_pw_shifter
   import spi_pw_pkg::*;
#(
   parameter int HALF_CLKS = 2,
   parameter int MAX_BITS  = 16,
   parameter int NB_W      = $clog2(MAX_BITS + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                go,
   input  logic [NB_W-1:0]     nbits,
   input  logic [MAX_BITS-1:0] tx,
   input  logic                miso,
   output logic                sck,
   output logic                mosi,
   output logic                last_bit,
   output logic                fin
);
   localparam int HT_W = $clog2(HALF_CLKS + 1);

   sh_phase_e           ph_q;
   logic                act_q;
   logic [MAX_BITS-1:0] sh_q, aligned;
   logic [NB_W-1:0]     left_q;
   logic [HT_W-1:0]     tmr_q;

   assign aligned = tx << (MAX_BITS - int'(nbits));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q     <= PH_SETUP;
         act_q    <= 1'b0;
         sh_q     <= '0;
         left_q   <= '0;
         tmr_q    <= '0;
         sck      <= 1'b0;
         mosi     <= 1'b0;
         last_bit <= 1'b0;
         fin      <= 1'b0;
      end else begin
         fin <= 1'b0;
         if (!act_q) begin
            if (go) begin
               act_q  <= 1'b1;
               sh_q   <= aligned;
               mosi   <= aligned[MAX_BITS-1];
               left_q <= nbits;
               ph_q   <= PH_SETUP;
               tmr_q  <= HT_W'(HALF_CLKS - 1);
            end
         end else if (tmr_q != '0) begin
            tmr_q <= tmr_q - 1'b1;
         end else begin
            tmr_q <= HT_W'(HALF_CLKS - 1);
            case (ph_q)
               PH_SETUP: begin
                  sck  <= 1'b1;
                  ph_q <= PH_HIGH;
               end
               PH_HIGH: begin
                  last_bit <= miso;
                  sck      <= 1'b0;
                  ph_q     <= PH_LOW;
               end
               default: begin
                  if (left_q == NB_W'(1)) begin
                     act_q <= 1'b0;
                     mosi  <= 1'b0;
                     fin   <= 1'b1;
                  end else begin
                     left_q <= left_q - 1'b1;
                     sh_q   <= sh_q << 1;
                     mosi   <= sh_q[MAX_BITS-2];
                     ph_q   <= PH_SETUP;
                  end
               end
            endcase
         end
      end
   end
endmodule

// File: rtl/spi_page_writer.sv
module spi_page_writer
   import spi_pw_pkg::*;
#(
   parameter int DEV_WORDS   = 256,
   parameter int IDX_W       = 16,
   parameter int OPC_W       = 8,
   parameter int ADDR_W      = 8,
   parameter int PAGE_BYTES  = 32,
   parameter int HALF_CLKS   = 2,
   parameter int PROG_CYCLES = 500000,
   parameter int GRANT_POLLS = 64,
   parameter int READY_TRIES = 100
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [IDX_W-1:0] start_offset,
   input  logic [IDX_W-1:0] start_count,
   output logic [IDX_W-1:0] word_idx,
   input  logic [15:0]      word_data,
   output logic             acc_req,
   input  logic             acc_gnt,
   output logic             spi_cs,
   output logic             spi_sck,
   output logic             spi_mosi,
   input  logic             spi_miso,
   output logic             busy,
   output logic             done,
   output logic             err
);
   localparam int TMR_MAX = (PROG_CYCLES > HALF_CLKS) ? PROG_CYCLES : HALF_CLKS;
   localparam int TMR_W   = $clog2(TMR_MAX + 1);
   localparam int POLL_W  = $clog2(GRANT_POLLS + 1);
   localparam int TRY_W   = $clog2(READY_TRIES + 1);
   localparam int NB_W    = $clog2(17);
   localparam int PG_LSB  = $clog2(PAGE_BYTES);

   if (PAGE_BYTES < 2 || (PAGE_BYTES & (PAGE_BYTES - 1)) != 0) begin : g_bad_page
      $error("PAGE_BYTES must be a power of two of at least 2");
   end
   if (OPC_W < 8 || OPC_W > 16 || ADDR_W < 1 || ADDR_W > 16) begin : g_bad_width
      $error("OPC_W must be 8..16 and ADDR_W 1..16");
   end
   if (HALF_CLKS < 1 || GRANT_POLLS < 1 || READY_TRIES < 1 || PROG_CYCLES < 1) begin : g_bad_count
      $error("timing and retry parameters must be positive");
   end

   pw_state_e        st_q, ret_q;
   logic             cs_q, req_q, done_q, err_q, kick_q;
   logic [15:0]      tx_q;
   logic [NB_W-1:0]  nb_q;
   logic [IDX_W-1:0] base_q, cnt_q, widx_q, cur_idx;
   logic [TMR_W-1:0] tmr_q;
   logic [POLL_W-1:0] poll_q;
   logic [TRY_W-1:0] tries_q;
   logic             bad, hi_addr, at_page;
   logic             sh_fin, sh_last;
   logic [7:0]       wr_op;

   assign cur_idx  = base_q + widx_q;
   assign word_idx = cur_idx;
   assign wr_op    = OP_WRITE | (hi_addr ? OP_HIADDR : 8'h00);

   // ninth address bit folded into the opcode only for 8-bit addressing
   if (ADDR_W == 8) begin : g_fold
      assign hi_addr = (cur_idx >= IDX_W'(128));
   end else begin : g_nofold
      assign hi_addr = 1'b0;
   end

   // byte address 2*idx is page aligned when idx's low PG_LSB-1 bits are zero
   if (PG_LSB == 1) begin : g_word_page
      assign at_page = 1'b1;
   end else begin : g_multi_page
      assign at_page = (cur_idx[PG_LSB-2:0] == '0);
   end

   spi_pw_bounds #(.DEV_WORDS(DEV_WORDS), .IDX_W(IDX_W)) u_bounds (
      .offset (start_offset),
      .count  (start_count),
      .bad    (bad)
   );

   spi_pw_shifter #(.HALF_CLKS(HALF_CLKS), .MAX_BITS(16), .NB_W(NB_W)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .go       (kick_q),
      .nbits    (nb_q),
      .tx       (tx_q),
      .miso     (spi_miso),
      .sck      (spi_sck),
      .mosi     (spi_mosi),
      .last_bit (sh_last),
      .fin      (sh_fin)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= S_IDLE;
         ret_q   <= S_IDLE;
         cs_q    <= 1'b1;
         req_q   <= 1'b0;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
         kick_q  <= 1'b0;
         tx_q    <= '0;
         nb_q    <= '0;
         base_q  <= '0;
         cnt_q   <= '0;
         widx_q  <= '0;
         tmr_q   <= '0;
         poll_q  <= '0;
         tries_q <= '0;
      end else begin
         kick_q <= 1'b0;
         done_q <= 1'b0;
         err_q  <= 1'b0;
         if (tmr_q != '0) tmr_q <= tmr_q - 1'b1;
         case (st_q)
            S_IDLE: if (start) begin
               if (bad) begin
                  err_q <= 1'b1;
               end else begin
                  base_q <= start_offset;
                  cnt_q  <= start_count;
                  widx_q <= '0;
                  poll_q <= '0;
                  st_q   <= S_ACQ;
               end
            end
            S_ACQ: begin
               req_q <= 1'b1;
               if (req_q && acc_gnt) begin
                  cs_q    <= 1'b0;
                  tmr_q   <= TMR_W'(HALF_CLKS - 1);
                  tries_q <= '0;
                  st_q    <= S_SEL;
               end else if (req_q) begin
                  if (poll_q == POLL_W'(GRANT_POLLS - 1)) begin
                     req_q <= 1'b0;
                     err_q <= 1'b1;
                     st_q  <= S_IDLE;
                  end else begin
                     poll_q <= poll_q + 1'b1;
                  end
               end
            end
            S_SEL: if (tmr_q == '0) begin
               kick_q <= 1'b1;
               tx_q   <= {8'h00, OP_STATUS};
               nb_q   <= NB_W'(OPC_W);
               st_q   <= S_RDSR;
            end
            S_RDSR: if (sh_fin) begin
               kick_q <= 1'b1;
               tx_q   <= '0;
               nb_q   <= NB_W'(8);
               st_q   <= S_STAT;
            end
            S_STAT: if (sh_fin) begin
               if (!sh_last) begin
                  ret_q <= S_WREN;
                  cs_q  <= 1'b1;
                  tmr_q <= TMR_W'(HALF_CLKS - 1);
                  st_q  <= S_PHI;
               end else if (tries_q == TRY_W'(READY_TRIES - 1)) begin
                  cs_q  <= 1'b1;
                  req_q <= 1'b0;
                  err_q <= 1'b1;
                  st_q  <= S_IDLE;
               end else begin
                  tries_q <= tries_q + 1'b1;
                  ret_q   <= S_RDSR;
                  cs_q    <= 1'b1;
                  tmr_q   <= TMR_W'(HALF_CLKS - 1);
                  st_q    <= S_PHI;
               end
            end
            S_PHI: if (tmr_q == '0) begin
               cs_q  <= 1'b0;
               tmr_q <= TMR_W'(HALF_CLKS - 1);
               st_q  <= S_PLO;
            end
            S_PLO: if (tmr_q == '0) begin
               st_q <= ret_q;
               case (ret_q)
                  S_RDSR: begin
                     kick_q <= 1'b1;
                     tx_q   <= {8'h00, OP_STATUS};
                     nb_q   <= NB_W'(OPC_W);
                  end
                  S_WREN: begin
                     kick_q <= 1'b1;
                     tx_q   <= {8'h00, OP_WREN};
                     nb_q   <= NB_W'(OPC_W);
                  end
                  S_WROP: begin
                     kick_q <= 1'b1;
                     tx_q   <= {8'h00, wr_op};
                     nb_q   <= NB_W'(OPC_W);
                  end
                  default: tmr_q <= TMR_W'(PROG_CYCLES - 1);
               endcase
            end
            S_WREN: if (sh_fin) begin
               ret_q <= S_WROP;
               cs_q  <= 1'b1;
               tmr_q <= TMR_W'(HALF_CLKS - 1);
               st_q  <= S_PHI;
            end
            S_WROP: if (sh_fin) begin
               kick_q <= 1'b1;
               tx_q   <= 16'(ADDR_W'({cur_idx, 1'b0}));
               nb_q   <= NB_W'(ADDR_W);
               st_q   <= S_ADDR;
            end
            S_ADDR: if (sh_fin) begin
               kick_q <= 1'b1;
               tx_q   <= {word_data[7:0], word_data[15:8]};
               nb_q   <= NB_W'(16);
               st_q   <= S_DATA;
            end
            S_DATA: if (sh_fin) begin
               widx_q <= widx_q + 1'b1;
               st_q   <= S_NEXT;
            end
            S_NEXT: begin
               if (widx_q == cnt_q) begin
                  tmr_q <= TMR_W'(PROG_CYCLES - 1);
                  st_q  <= S_PROG;
               end else if (at_page) begin
                  ret_q <= S_PROG;
                  cs_q  <= 1'b1;
                  tmr_q <= TMR_W'(HALF_CLKS - 1);
                  st_q  <= S_PHI;
               end else begin
                  kick_q <= 1'b1;
                  tx_q   <= {word_data[7:0], word_data[15:8]};
                  nb_q   <= NB_W'(16);
                  st_q   <= S_DATA;
               end
            end
            S_PROG: if (tmr_q == '0) begin
               cs_q  <= 1'b1;
               req_q <= 1'b0;
               if (widx_q == cnt_q) begin
                  done_q <= 1'b1;
                  st_q   <= S_IDLE;
               end else begin
                  poll_q <= '0;
                  st_q   <= S_ACQ;
               end
            end
            default: st_q <= S_IDLE;
         endcase
      end
   end

   assign spi_cs  = cs_q;
   assign acc_req = req_q;
   assign busy    = (st_q != S_IDLE);
   assign done    = done_q;
   assign err     = err_q;
endmodule

// File: rtl/spi_page_writer_chk.sv
module spi_page_writer_chk (
   input logic clk,
   input logic rst_n,
   input logic start,
   input logic acc_req,
   input logic spi_cs,
   input logic spi_sck,
   input logic spi_mosi,
   input logic busy,
   input logic done,
   input logic err
);
   // R2
   deselect_without_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_req |-> spi_cs);

   // R10
   sck_parked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      spi_cs |-> !spi_sck);

   // R10
   mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi));

   // R11
   req_within_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !acc_req);

   // R11
   single_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && err));

   // R11
   accept_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));
endmodule

bind spi_page_writer spi_page_writer_chk u_chk (.*);

// File: tb/spi_page_writer_bench.sv
module spi_page_writer_bench;
   localparam int CLK_PERIOD = 10;
   localparam int WORDS = 256, PAGE = 16, PROG = 40, GPOLL = 6, TRIES = 3;

   logic clk = 0, rst_n = 0, start = 0, acc_gnt = 0, spi_miso = 0, gnt_en = 1;
   logic [15:0] start_offset = 0, start_count = 0, word_idx, word_data;
   logic acc_req, spi_cs, spi_sck, spi_mosi, busy, done, err;

   int n_cmp = 0, n_bad = 0, cyc = 0;
   logic [15:0] src [0:255];
   logic [7:0]  dmem [0:511];
   bit fbits[$];
   int n_wren = 0, n_wr = 0, n_rdsr = 0, n_a8 = 0, cs_falls = 0, req_rises = 0;
   int busy_left = 0, last_op = 0, last_addr = 0, last_fall = 0, e;
   bit wel = 0, st_busy = 0, data_seen = 0, acc_edge = 0, exp_busy = 0, live = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   assign word_data = src[word_idx[7:0]];

   spi_page_writer #(.DEV_WORDS(WORDS), .IDX_W(16), .OPC_W(8), .ADDR_W(8),
      .PAGE_BYTES(PAGE), .HALF_CLKS(1), .PROG_CYCLES(PROG),
      .GRANT_POLLS(GPOLL), .READY_TRIES(TRIES)) u_spi_page_writer (
      .clk(clk), .rst_n(rst_n), .start(start), .start_offset(start_offset),
      .start_count(start_count), .word_idx(word_idx), .word_data(word_data),
      .acc_req(acc_req), .acc_gnt(acc_gnt), .spi_cs(spi_cs), .spi_sck(spi_sck),
      .spi_mosi(spi_mosi), .spi_miso(spi_miso), .busy(busy), .done(done), .err(err));

   task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h at cycle %0d", rq, act, exp, cyc);
      end
   endtask

   function automatic bit args_ok(input int off, input int cnt);
      return (off < WORDS) && (cnt != 0) && (cnt <= WORDS - off);
   endfunction

   function automatic int fr_val(input int s, input int n);
      int v = 0;
      for (int i = 0; i < n; i++) v = (v << 1) | int'(fbits[s+i]);
      return v;
   endfunction

   // grant follows the request one cycle later when enabled
   always @(posedge clk) acc_gnt <= gnt_en & acc_req;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      acc_edge <= start && !busy && args_ok(int'(start_offset), int'(start_count));
   end

   // cycle reference model of busy (R11)
   always @(negedge clk) if (live) begin
      if (acc_edge) exp_busy = 1;
      if (done || err) exp_busy = 0;
      chk(busy == exp_busy, "R11 busy", busy, exp_busy);
      if (cyc > 150000) begin
         chk(0, "R11 watchdog", cyc, 150000);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   always @(posedge acc_req) req_rises++;
   always @(negedge spi_sck) last_fall = cyc;
   always @(negedge acc_req) if (live) begin
      if (data_seen) chk(cyc - last_fall >= PROG, "R9 program wait", cyc - last_fall, PROG);
      data_seen = 0;
   end

   // behavioural device model
   always @(negedge spi_cs) begin
      fbits.delete();
      cs_falls++;
   end

   always @(posedge spi_sck) if (!spi_cs) begin
      fbits.push_back(spi_mosi);
      e = fbits.size() - 1;
      if (e == 8) st_busy = (busy_left > 0);
      if (e == 15 && fr_val(0, 8) == 8'h05) spi_miso <= st_busy;
      if (e >= 16 && (fr_val(0, 8) == 8'h02 || fr_val(0, 8) == 8'h0A)) data_seen = 1;
   end

   always @(posedge spi_cs) if (live && fbits.size() > 0) begin
      int op, a, nb;
      chk(spi_mosi == 0, "R10 mosi idle at frame end", spi_mosi, 0);
      spi_miso <= 0;
      op = (fbits.size() >= 8) ? fr_val(0, 8) : -1;
      if (op == 8'h05) begin
         n_rdsr++;
         if (busy_left > 0) busy_left--;
      end else if (op == 8'h06 && fbits.size() == 8) begin
         n_wren++; wel = 1;
      end else if ((op == 8'h02 || op == 8'h0A) && fbits.size() >= 16) begin
         n_wr++; last_op = op;
         if (op == 8'h0A) n_a8++;
         last_addr = fr_val(8, 8);
         a = ((op >> 3) & 1) * 256 + last_addr;
         nb = (fbits.size() - 16) / 8;
         if (wel)
            for (int b = 0; b < nb; b++)
               dmem[(a & ~(PAGE-1)) | ((a + b) & (PAGE-1))] = 8'(fr_val(16 + 8*b, 8));
         wel = 0;
      end
   end

   task automatic run(input int off, input int cnt, output bit got_err);
      @(negedge clk);
      start_offset = 16'(off); start_count = 16'(cnt); start = 1;
      @(negedge clk);
      start = 0;
      while (!(done || err)) @(negedge clk);
      got_err = err;
      repeat (3) @(negedge clk);
   endtask

   task automatic chk_mem(input int off, input int cnt, input string rq);
      for (int i = 0; i < cnt; i++) begin
         int ix = off + i;
         chk({dmem[2*ix+1], dmem[2*ix]} == src[ix], rq, {dmem[2*ix+1], dmem[2*ix]}, src[ix]);
      end
   endtask

   initial begin
      bit ge;
      int w0, r0, s0, a0, c0, q0;
      for (int i = 0; i < 256; i++) src[i] = 16'((i * 16'h0123) ^ 16'hA55A);
      for (int i = 0; i < 512; i++) dmem[i] = 8'h00;
      repeat (3) @(negedge clk);
      // R12 reset state
      chk(spi_cs == 1 && spi_sck == 0 && spi_mosi == 0, "R12 link idle", {spi_cs, spi_sck, spi_mosi}, 3'b100);
      chk(acc_req == 0 && busy == 0 && done == 0 && err == 0, "R12 status idle",
          {acc_req, busy, done, err}, 0);
      rst_n = 1; live = 1;
      @(negedge clk);

      // single burst inside one page
      w0 = n_wr; r0 = n_rdsr; s0 = n_wren; a0 = n_a8;
      run(2, 3, ge);
      chk(ge == 0, "R11 done", ge, 0);
      chk(n_rdsr - r0 == 1, "R3 one status poll", n_rdsr - r0, 1);
      chk(n_wren - s0 == 1, "R4 write enable frame", n_wren - s0, 1);
      chk(n_wr - w0 == 1 && n_a8 == a0, "R5 plain write opcode", last_op, 2);
      chk(last_addr == 4, "R6 byte address", last_addr, 4);
      chk_mem(2, 3, "R7 data bytes");

      // run crossing a page boundary mid-stream
      w0 = n_wr; s0 = n_wren;
      run(5, 10, ge);
      chk(n_wr - w0 == 2, "R8 two bursts", n_wr - w0, 2);
      chk(n_wren - s0 == 2, "R4 enable per burst", n_wren - s0, 2);
      chk(last_addr == 16, "R6 second burst address", last_addr, 16);
      chk_mem(5, 10, "R7 split run data");

      // run ending exactly at a page end: count end wins, no extra pulse
      w0 = n_wr; c0 = cs_falls;
      run(8, 8, ge);
      chk(n_wr - w0 == 1, "R8 single burst at page end", n_wr - w0, 1);
      chk(cs_falls - c0 == 3, "R8 no boundary pulse", cs_falls - c0, 3);
      chk_mem(8, 8, "R7 page end data");

      // crossing index 128 folds the ninth address bit
      a0 = n_a8;
      run(126, 4, ge);
      chk(n_a8 - a0 == 1 && last_op == 8'h0A, "R5 high address opcode", last_op, 8'h0A);
      chk(last_addr == 0, "R6 truncated address", last_addr, 0);
      chk_mem(126, 4, "R7 high half data");

      // device busy twice before ready
      r0 = n_rdsr; busy_left = 2;
      run(40, 1, ge);
      chk(ge == 0 && n_rdsr - r0 == 3, "R3 retry until ready", n_rdsr - r0, 3);
      chk_mem(40, 1, "R7 after retries");

      // device never ready
      r0 = n_rdsr; w0 = n_wr; busy_left = 1000;
      run(60, 1, ge);
      chk(ge == 1, "R3 ready failure error", ge, 1);
      chk(n_rdsr - r0 == TRIES, "R3 retry limit", n_rdsr - r0, TRIES);
      chk(n_wr == w0 && acc_req == 0 && spi_cs == 1, "R3 released without write", n_wr - w0, 0);
      busy_left = 0;

      // grant never arrives
      gnt_en = 0; c0 = cs_falls;
      run(0, 1, ge);
      chk(ge == 1, "R2 grant timeout error", ge, 1);
      chk(cs_falls == c0 && acc_req == 0, "R2 no select, request dropped", cs_falls - c0, 0);
      gnt_en = 1;

      // bounds
      q0 = req_rises;
      run(256, 1, ge); chk(ge == 1, "R1 offset too large", ge, 1);
      run(10, 0, ge);  chk(ge == 1, "R1 zero count", ge, 1);
      run(250, 7, ge); chk(ge == 1, "R1 count past end", ge, 1);
      chk(req_rises == q0, "R1 no access request", req_rises - q0, 0);
      run(250, 6, ge); chk(ge == 0, "R1 last word accepted", ge, 0);
      chk_mem(250, 6, "R1 tail data");

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule